// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block times one programmed-I/O transfer on an IDE-style device bus. A cycle always runs through three phases. First the address and chip select settle. Then the read or the write strobe is driven. Finally a hold phase keeps the chip select up after the strobe drops. The length of each phase is decoded from a packed 8-bit timing byte. The codes are non-linear, so slow and fast device modes can both be reached with only a few bits.

Two timing bytes are supplied: one for data-port transfers and one for command/control register transfers. A select input picks between them at the moment a cycle starts. The device ready line can optionally stretch the strobe. Read data from the device bus is captured when the strobe phase ends. A one-clock done pulse marks the end of every cycle.

Top module: `pio_strobe_timer`

## Requirements
- R1: The setup phase (cs_o high, both strobes low, before the strobe) lasts 1, 2, 3 or 4 clocks for timing-byte bits [7:6] = 0, 1, 2, 3.
- R2: The strobe phase lasts 2, 3, 4, 5, 6, 8, 12 or 16 clocks for timing-byte bits [2:0] = 0 to 7 (IORDY not stretching).
- R3: The hold phase (cs_o high, strobes low, after the strobe) lasts 1, 2, 3, 4, 5, 6, 8 or 12 clocks for timing-byte bits [5:3] = 0 to 7.
- R4: The cycle uses cmd_tmg_i when cmd_sel_i is 1 at the start, and data_tmg_i when it is 0.
- R5: The timing byte is taken when the start is accepted. A change of either timing input during a busy cycle only affects later cycles.
- R6: With iordy_en_i = 1, if iordy_i is low in the last programmed strobe clock, the strobe continues one clock at a time until a clock in which iordy_i is high. That clock is the last strobe clock.
- R7: With iordy_en_i = 0, iordy_i has no effect on any phase length.
- R8: done_o is high for exactly one clock, the clock right after the last hold clock. busy_o is low in that clock, and a new start may be accepted there.
- R9: start_i is accepted only while busy_o is low. A start while busy neither restarts nor extends the cycle, and does not queue another cycle.
- R10: For a read, rdata_o takes the value dd_i had in the last strobe clock, visible from the next clock on. Writes and idle clocks leave rdata_o unchanged.
- R11: write_i at the start selects wr_stb_o (1) or rd_stb_o (0). The two strobes are never high together. cs_o and busy_o are high through all three phases.
- R12: After reset all outputs are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one transfer cycle |
| write_i | input | 1 | 1 = write, 0 = read, sampled at start |
| cmd_sel_i | input | 1 | 1 = command/control port, 0 = data port |
| data_tmg_i | input | 8 | Timing byte for data-port cycles |
| cmd_tmg_i | input | 8 | Timing byte for command/control cycles |
| iordy_i | input | 1 | Device ready line |
| iordy_en_i | input | 1 | 1 = honour iordy_i |
| dd_i | input | DW | Device data bus, read side |
| cs_o | output | 1 | Address/chip-select valid |
| rd_stb_o | output | 1 | Read strobe, active high |
| wr_stb_o | output | 1 | Write strobe, active high |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| rdata_o | output | DW | Captured read data |

## Verification
Some rules are checked by the embedded assertions on every clock: the strobes never overlap, a strobe is never outside chip select, done is a single clock that follows the fall of busy, busy rises only after a start, the strobe is held while ready is low at the programmed end, and rdata_o holds outside a read capture. Only the bench scenarios can show the exact phase lengths for every code of the three fields, the choice between the two timing bytes, the sampling of the byte at start, and that a start while busy is dropped. A behavioural model runs alongside the design and is compared on every clock.

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          write_i,
  input  logic          cmd_sel_i,
  input  logic [7:0]    data_tmg_i,
  input  logic [7:0]    cmd_tmg_i,
  input  logic          iordy_i,
  input  logic          iordy_en_i,
  input  logic [DW-1:0] dd_i,
  output logic          cs_o,
  output logic          rd_stb_o,
  output logic          wr_stb_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);

  typedef enum logic [1:0] {P_IDLE, P_SETUP, P_ACT, P_HOLD} phase_t;

  phase_t      ph;
  logic [3:0]  cnt;
  logic [7:0]  tmg_q;
  logic        wr_q;
  logic        done_q;
  logic [DW-1:0] rdata_q;

  // Each decoder returns the phase length minus one.
  function automatic logic [3:0] setup_m1(input logic [7:0] b);
    return {2'b00, b[7:6]};
  endfunction

  function automatic logic [3:0] act_m1(input logic [7:0] b);
    case (b[2:0])
      3'd5:    return 4'd7;
      3'd6:    return 4'd11;
      3'd7:    return 4'd15;
      default: return {1'b0, b[2:0]} + 4'd1;
    endcase
  endfunction

  function automatic logic [3:0] hold_m1(input logic [7:0] b);
    case (b[5:3])
      3'd6:    return 4'd7;
      3'd7:    return 4'd11;
      default: return {1'b0, b[5:3]};
    endcase
  endfunction

  wire [7:0] tmg_sel  = cmd_sel_i ? cmd_tmg_i : data_tmg_i;
  wire       last     = (cnt == 4'd0);
  wire       wait_rdy = iordy_en_i && !iordy_i;
  wire       capture  = (ph == P_ACT) && last && !wait_rdy && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= P_IDLE;
      cnt     <= '0;
      tmg_q   <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (capture) rdata_q <= dd_i;
      case (ph)
        P_IDLE: if (start_i) begin
          ph    <= P_SETUP;
          tmg_q <= tmg_sel;
          wr_q  <= write_i;
          cnt   <= setup_m1(tmg_sel);
        end
        P_SETUP: if (last) begin
          ph  <= P_ACT;
          cnt <= act_m1(tmg_q);
        end else cnt <= cnt - 4'd1;
        P_ACT: if (!last) cnt <= cnt - 4'd1;
        else if (!wait_rdy) begin
          ph  <= P_HOLD;
          cnt <= hold_m1(tmg_q);
        end
        default: if (last) begin
          ph     <= P_IDLE;
          done_q <= 1'b1;
        end else cnt <= cnt - 4'd1;
      endcase
    end
  end

  assign busy_o   = (ph != P_IDLE);
  assign cs_o     = busy_o;
  assign rd_stb_o = (ph == P_ACT) && !wr_q;
  assign wr_stb_o = (ph == P_ACT) && wr_q;
  assign done_o   = done_q;
  assign rdata_o  = rdata_q;

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb_o && wr_stb_o));
  assert_strobe_in_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_o || wr_stb_o) |-> cs_o);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  assert_iordy_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_stb_o || wr_stb_o) && last && iordy_en_i && !iordy_i) |=> (rd_stb_o || wr_stb_o));
  assert_strobe_then_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_stb_o || wr_stb_o) |-> (cs_o && !done_o));
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_o |=> $stable(rdata_o));

endmodule

// File: tb/pio_strobe_timer_tb.sv
`timescale 1ns/1ps
module pio_strobe_timer_tb;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, write_i = 0, cmd_sel_i = 0, iordy_i = 1, iordy_en_i = 0;
  logic [7:0] data_tmg_i = 8'hF5, cmd_tmg_i = 8'hDE;
  logic [DW-1:0] dd_i = '0;
  logic cs_o, rd_stb_o, wr_stb_o, busy_o, done_o;
  logic [DW-1:0] rdata_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pio_strobe_timer #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
    .cmd_sel_i(cmd_sel_i), .data_tmg_i(data_tmg_i), .cmd_tmg_i(cmd_tmg_i),
    .iordy_i(iordy_i), .iordy_en_i(iordy_en_i), .dd_i(dd_i),
    .cs_o(cs_o), .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o));

  int act_tab[8]  = '{2, 3, 4, 5, 6, 8, 12, 16};
  int hold_tab[8] = '{1, 2, 3, 4, 5, 6, 8, 12};

  function automatic int setup_len(input logic [7:0] b); return int'(b[7:6]) + 1; endfunction
  function automatic int act_len(input logic [7:0] b);   return act_tab[b[2:0]];  endfunction
  function automatic int hold_len(input logic [7:0] b);  return hold_tab[b[5:3]]; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: phase number, clocks left in phase
  int m_ph = 0, m_left = 0;
  bit m_wr = 0, m_done = 0;
  logic [7:0] m_byte = 0;
  logic [DW-1:0] m_rdata = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_wr = 0; m_done = 0; m_rdata = '0;
    end else begin
      m_done = 0;
      if (m_ph == 0) begin
        if (start_i) begin
          m_byte = cmd_sel_i ? cmd_tmg_i : data_tmg_i;
          m_wr = write_i; m_ph = 1; m_left = setup_len(m_byte);
        end
      end else if (m_left > 1) m_left--;
      else if (m_ph == 1) begin m_ph = 2; m_left = act_len(m_byte); end
      else if (m_ph == 2) begin
        if (!(iordy_en_i && !iordy_i)) begin
          if (!m_wr) m_rdata = dd_i;
          m_ph = 3; m_left = hold_len(m_byte);
        end
      end else begin m_ph = 0; m_done = 1; end
    end
  end

  always @(negedge clk) begin
    dd_i <= dd_i + 16'h0101;
    if (rst_n && !finished) begin
      check(busy_o == (m_ph != 0) && cs_o == (m_ph != 0), "R11 busy/cs vs model", busy_o, m_ph != 0);
      check(rd_stb_o == (m_ph == 2 && !m_wr), "R11 rd_stb vs model", rd_stb_o, m_ph == 2 && !m_wr);
      check(wr_stb_o == (m_ph == 2 && m_wr), "R11 wr_stb vs model", wr_stb_o, m_ph == 2 && m_wr);
      check(done_o == m_done, "R8 done vs model", done_o, m_done);
      check(rdata_o == m_rdata, "R10 rdata vs model", rdata_o, m_rdata);
    end
  end

  int s_n, a_n, h_n;

  task automatic xfer(input bit w, input bit c, input bit chg, input logic [7:0] nb);
    int guard;
    @(negedge clk);
    write_i = w; cmd_sel_i = c; start_i = 1;
    @(negedge clk);
    start_i = 0;
    s_n = 0; a_n = 0; h_n = 0; guard = 0;
    if (chg) begin data_tmg_i = nb; cmd_tmg_i = nb; end
    while (!done_o && guard < 200) begin
      if (rd_stb_o || wr_stb_o) a_n++;
      else if (busy_o && a_n == 0) s_n++;
      else if (busy_o) h_n++;
      guard++;
      @(negedge clk);
    end
    check(done_o && !busy_o, "R8 done with busy low", busy_o, 0);
    @(negedge clk);
    check(!done_o, "R8 done one clock", done_o, 0);
  endtask

  task automatic check_len(input logic [7:0] b, input string tag);
    check(s_n == setup_len(b), {tag, " setup"}, s_n, setup_len(b));
    check(a_n == act_len(b),   {tag, " active"}, a_n, act_len(b));
    check(h_n == hold_len(b),  {tag, " hold"}, h_n, hold_len(b));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!cs_o && !rd_stb_o && !wr_stb_o && !busy_o && !done_o && rdata_o == 0,
          "R12 reset outputs", busy_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < 4; k++) begin
      data_tmg_i = {k[1:0], 6'b000_000};
      xfer(0, 0, 0, 0);
      check(s_n == k + 1, "R1 setup code", s_n, k + 1);
    end
    for (int k = 0; k < 8; k++) begin
      data_tmg_i = {5'b01_000, k[2:0]};
      xfer(0, 0, 0, 0);
      check(a_n == act_tab[k], "R2 active code", a_n, act_tab[k]);
    end
    for (int k = 0; k < 8; k++) begin
      data_tmg_i = {2'b00, k[2:0], 3'b001};
      xfer(1, 0, 0, 0);
      check(h_n == hold_tab[k], "R3 hold code", h_n, hold_tab[k]);
    end

    data_tmg_i = 8'hF5; cmd_tmg_i = 8'hDE;
    xfer(1, 1, 0, 0);  check_len(8'hDE, "R4 cmd byte");
    xfer(0, 0, 0, 0);  check_len(8'hF5, "R4 data byte");
    data_tmg_i = 8'h09;
    xfer(0, 0, 0, 0);  check_len(8'h09, "R4 data byte 09");

    data_tmg_i = 8'h00;
    xfer(0, 0, 1, 8'hFF); check_len(8'h00, "R5 byte held in cycle");
    xfer(0, 0, 0, 0);     check_len(8'hFF, "R5 new byte next cycle");

    data_tmg_i = 8'h00; iordy_en_i = 0; iordy_i = 0;
    xfer(0, 0, 0, 0); check_len(8'h00, "R7 iordy ignored");

    iordy_en_i = 1; iordy_i = 0;
    fork
      xfer(0, 0, 0, 0);
      begin repeat (8) @(negedge clk); iordy_i = 1; end
    join
    check(a_n > act_len(8'h00), "R6 strobe stretched", a_n, act_len(8'h00) + 1);
    check(s_n == 1 && h_n == 1, "R6 other phases unchanged", s_n + h_n, 2);
    iordy_en_i = 0;

    begin
      logic [DW-1:0] keep;
      data_tmg_i = 8'h09;
      xfer(0, 0, 0, 0);
      check(rdata_o == m_rdata, "R10 read capture", rdata_o, m_rdata);
      keep = rdata_o;
      xfer(1, 0, 0, 0);
      check(rdata_o == keep, "R10 write leaves rdata", rdata_o, keep);
    end

    data_tmg_i = 8'h40;
    @(negedge clk); write_i = 0; cmd_sel_i = 0; start_i = 1;
    @(negedge clk); start_i = 0;
    @(negedge clk); @(negedge clk);
    start_i = 1;
    @(negedge clk); start_i = 0;
    begin
      int g = 0;
      while (!done_o && g < 100) begin g++; @(negedge clk); end
    end
    @(negedge clk);
    check(!busy_o, "R9 start while busy dropped", busy_o, 0);
    @(negedge clk);
    check(!busy_o, "R9 no queued cycle", busy_o, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule